// File: doc/BRIEF.md
# Nibble-Wide Tone Transceiver Register Port

This block is the processor-facing register port of a tone-signalling transceiver. A 4-bit processor bus reaches it through an active-low chip select, one register-select line, a read/write line and a bus phase strobe. An access exists only while chip select is low and the phase strobe is high. The block samples these signals with its own system clock. The port holds a transmit code register and two control registers that share one address. It shows a receive code supplied by the tone validator, and it keeps a status register whose flags clear when they are read.

The control registers drive the mode outputs of the tone generator and the receiver:
- tone output enable
- call-progress mode
- interrupt enable
- burst mode
- test mode
- single-tone mode
- column/row select

An active-low interrupt pin reports one of four things, depending on the mode bits:
- received-digit events
- transmit-ready events
- the raw call-progress comparator squarewave
- the inverted delayed-steering level

The access controller is a three-state machine:
- `ACC_IDLE` waits for a selected access. On the transition `IDLE->ACTIVE` it latches the access kind and takes a snapshot of the status and receive code.
- `ACC_ACTIVE` follows the write data and drives read data for as long as the access lasts. On the transition `ACTIVE->CLOSE` the access ends.
- `ACC_CLOSE` issues the one-cycle commit for the latched kind: a transmit write, a control write or a status clear. The transition `CLOSE->IDLE` follows always.

The interrupt source selector picks one of four sources: `SRC_OFF`, `SRC_CALLPROG`, `SRC_STEER` and `SRC_EVENT`.

Top module: `tone_xcvr_port`

## Requirements
- R1: The access kind is taken from {register-select, read/write} at the start of an access: 00 writes the transmit code, 01 reads the receive code, 10 writes the control address, 11 reads status.
- R2: `bus_dout_en` is high only while chip select is low, the phase strobe is high and the access is a read. A low phase strobe with chip select low starts no access.
- R3: Control register A fields: bit 0 sets `tone_out_en`, bit 1 sets `cp_mode`, bit 2 sets `irq_en`, bit 3 is the redirect bit.
- R4: Control register B fields: bit 0 low sets `burst_on` high, bit 1 sets `test_on`, bit 2 sets `single_tone`, bit 3 sets `column_sel`.
- R5: A control write that lands in register A with bit 3 set sends only the next control write to register B. The write after that returns to register A. Register B is unchanged by writes that land in A.
- R6: After reset both control registers are zero, every status flag is clear, `irq_n` is 1, `bus_dout_en` is 0 and the control address points at register A.
- R7: Status layout: bit 2 is receive-full and bit 0 is interrupt-occurred. A `rx_full_evt` pulse sets both. Both clear when the status register is read.
- R8: Status bit 1 is transmit-empty. A `tx_empty_evt` pulse sets it, together with bit 0, only while `burst_on` is high. It clears on a status read and is held clear whenever `burst_on` is low.
- R9: Status bit 3 reads 1 when `dly_steer` is low at the start of the read, and 0 when it is high.
- R10: A status read returns the flags as they stood at the start of the access. At the end of the access it clears only the flags it returned as set. An event that arrives during the read stays set.
- R11: With `cp_mode` low, `test_on` low and `irq_en` high, `irq_n` goes low one cycle after receive-full or transmit-empty is set. It returns high once they are cleared.
- R12: With `cp_mode` high, `rx_full_evt` is ignored. With `irq_en` also high, `irq_n` follows `cp_sq` one cycle later. With `irq_en` low, `irq_n` stays 1.
- R13: With `cp_mode` low and `test_on` high, `irq_n` carries the inverse of `dly_steer`, one cycle later.
- R14: A transmit write places the written nibble on `tx_code` after the access ends, with a `tx_load` pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_phase | input | 1 | Bus phase strobe, access valid while high |
| bus_rsel | input | 1 | Register select line |
| bus_rd_wr_n | input | 1 | 1 = read, 0 = write |
| bus_din | input | 4 | Write data from the processor |
| bus_dout | output | 4 | Read data to the processor |
| bus_dout_en | output | 1 | Read data drive enable |
| rx_code | input | 4 | Code latched by the tone validator |
| rx_full_evt | input | 1 | One-cycle pulse: new received digit |
| tx_empty_evt | input | 1 | One-cycle pulse: burst and pause finished |
| dly_steer | input | 1 | Delayed-steering level from the validator |
| cp_sq | input | 1 | Call-progress comparator output |
| tx_code | output | 4 | Code for the tone generator |
| tx_load | output | 1 | One-cycle pulse when `tx_code` is written |
| tone_out_en | output | 1 | Tone output enable |
| cp_mode | output | 1 | Call-progress mode |
| irq_en | output | 1 | Interrupt enable |
| burst_on | output | 1 | Burst timing enabled |
| test_on | output | 1 | Test mode |
| single_tone | output | 1 | Single-tone generation |
| column_sel | output | 1 | Column (1) or row (0) single tone |
| irq_n | output | 1 | Active-low interrupt / multiplexed pin |

## Verification
The hardest case to reach is an event that arrives while a status read is in progress. It must land after the snapshot edge and before the clear, and it must survive the clear that follows. The bench reaches it by holding a status read open for several cycles. It fires `rx_full_evt` in the cycle after the snapshot is taken and then checks two things: the read value must lack the flag, and the next read must still show it. Burst-off clearing of transmit-empty is reached by setting the flag, then rewriting control register B through the redirect bit before any read.

// File: rtl/xp_port_pkg.sv
package xp_port_pkg;

    localparam int NIB = 4;

    // status bit positions (software decodes these)
    localparam int ST_IRQ = 0;
    localparam int ST_TXE = 1;
    localparam int ST_RXF = 2;
    localparam int ST_STR = 3;

    // control A
    localparam int CA_TONE = 0;
    localparam int CA_CPM  = 1;
    localparam int CA_IRQ  = 2;
    localparam int CA_RSEL = 3;

    // control B
    localparam int CB_BURSTN = 0;
    localparam int CB_TEST   = 1;
    localparam int CB_SINGLE = 2;
    localparam int CB_COL    = 3;

    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_ACTIVE = 2'd1,
        ACC_CLOSE  = 2'd2
    } acc_state_t;

    // {register select, read/not-write}
    typedef enum logic [1:0] {
        KIND_TXD = 2'b00,
        KIND_RXD = 2'b01,
        KIND_CTL = 2'b10,
        KIND_STS = 2'b11
    } acc_kind_t;

    typedef enum logic [1:0] {
        SRC_OFF      = 2'd0,
        SRC_CALLPROG = 2'd1,
        SRC_STEER    = 2'd2,
        SRC_EVENT    = 2'd3
    } irq_src_t;

endpackage

// File: rtl/xp_bus_fsm.sv
module xp_bus_fsm
    import xp_port_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          phase,
    input  logic          rsel,
    input  logic          rd_wr_n,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] status_now,
    input  logic [DW-1:0] rx_now,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          wr_tx,
    output logic          wr_ctl,
    output logic          rd_sts,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] snap_sts
);

    acc_state_t    state, nxt;
    acc_kind_t     kind;
    logic [DW-1:0] snap_rx;
    logic          sel;

    assign sel = ~cs_n & phase;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ACC_IDLE:   nxt = sel ? ACC_ACTIVE : ACC_IDLE;
            ACC_ACTIVE: nxt = sel ? ACC_ACTIVE : ACC_CLOSE;
            ACC_CLOSE:  nxt = ACC_IDLE;
            default:    nxt = ACC_IDLE;
        endcase
    end

    // state register and access capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ACC_IDLE;
            kind     <= KIND_TXD;
            snap_sts <= '0;
            snap_rx  <= '0;
            wdata    <= '0;
        end else begin
            state <= nxt;
            if (state == ACC_IDLE && sel) begin
                kind     <= acc_kind_t'({rsel, rd_wr_n});
                snap_sts <= status_now;
                snap_rx  <= rx_now;
                wdata    <= din;
            end else if (state == ACC_ACTIVE && sel) begin
                wdata <= din;
            end
        end
    end

    // outputs
    always_comb begin
        logic commit;
        commit  = (state == ACC_CLOSE);
        dout_en = (state == ACC_ACTIVE) && sel && kind[0];
        dout    = '0;
        if (dout_en)
            dout = (kind == KIND_STS) ? snap_sts : snap_rx;
        wr_tx   = commit && (kind == KIND_TXD);
        wr_ctl  = commit && (kind == KIND_CTL);
        rd_sts  = commit && (kind == KIND_STS);
    end

endmodule

// File: rtl/xp_ctrl_regs.sv
module xp_ctrl_regs
    import xp_port_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_tx,
    input  logic          wr_ctl,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_a,
    output logic [DW-1:0] ctrl_b,
    output logic [DW-1:0] tx_code,
    output logic          tx_load
);

    logic to_b;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_a  <= '0;
            ctrl_b  <= '0;
            to_b    <= 1'b0;
            tx_code <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= wr_tx;
            if (wr_tx)
                tx_code <= wdata;
            if (wr_ctl) begin
                if (to_b) begin
                    ctrl_b <= wdata;
                    to_b   <= 1'b0;
                end else begin
                    ctrl_a <= wdata;
                    to_b   <= wdata[CA_RSEL];
                end
            end
        end
    end

endmodule

// File: rtl/xp_status_flags.sv
module xp_status_flags
    import xp_port_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_full_evt,
    input  logic          tx_empty_evt,
    input  logic          dly_steer,
    input  logic          cp_mode,
    input  logic          burst_on,
    input  logic          rd_sts,
    input  logic [DW-1:0] snap_sts,
    output logic [DW-1:0] flags
);

    logic          rxf, txe, irqf;
    logic          rx_set, tx_set;
    logic [DW-1:0] clr;

    assign rx_set = rx_full_evt & ~cp_mode;
    assign tx_set = tx_empty_evt & burst_on;
    assign clr    = rd_sts ? snap_sts : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxf  <= 1'b0;
            txe  <= 1'b0;
            irqf <= 1'b0;
        end else begin
            rxf  <= rx_set | (rxf & ~clr[ST_RXF]);
            txe  <= burst_on & (tx_set | (txe & ~clr[ST_TXE]));
            irqf <= rx_set | tx_set | (irqf & ~clr[ST_IRQ]);
        end
    end

    always_comb begin
        flags         = '0;
        flags[ST_IRQ] = irqf;
        flags[ST_TXE] = txe;
        flags[ST_RXF] = rxf;
        flags[ST_STR] = ~dly_steer;
    end

endmodule

// File: rtl/xp_irq_mux.sv
module xp_irq_mux
    import xp_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cp_mode,
    input  logic irq_en,
    input  logic test_on,
    input  logic rx_full,
    input  logic tx_empty,
    input  logic cp_sq,
    input  logic dly_steer,
    output logic irq_n
);

    irq_src_t src;

    always_comb begin
        if (cp_mode)
            src = irq_en ? SRC_CALLPROG : SRC_OFF;
        else if (test_on)
            src = SRC_STEER;
        else if (irq_en)
            src = SRC_EVENT;
        else
            src = SRC_OFF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else begin
            unique case (src)
                SRC_OFF:      irq_n <= 1'b1;
                SRC_CALLPROG: irq_n <= cp_sq;
                SRC_STEER:    irq_n <= ~dly_steer;
                SRC_EVENT:    irq_n <= ~(rx_full | tx_empty);
                default:      irq_n <= 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/tone_xcvr_port.sv
module tone_xcvr_port
    import xp_port_pkg::*;
#(
    parameter int DW = NIB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs_n,
    input  logic          bus_phase,
    input  logic          bus_rsel,
    input  logic          bus_rd_wr_n,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_en,
    input  logic [DW-1:0] rx_code,
    input  logic          rx_full_evt,
    input  logic          tx_empty_evt,
    input  logic          dly_steer,
    input  logic          cp_sq,
    output logic [DW-1:0] tx_code,
    output logic          tx_load,
    output logic          tone_out_en,
    output logic          cp_mode,
    output logic          irq_en,
    output logic          burst_on,
    output logic          test_on,
    output logic          single_tone,
    output logic          column_sel,
    output logic          irq_n
);

    logic [DW-1:0] flags, snap_sts, wdata, ctrl_a, ctrl_b;
    logic          wr_tx, wr_ctl, rd_sts;

    xp_bus_fsm #(.DW(DW)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (bus_cs_n),
        .phase      (bus_phase),
        .rsel       (bus_rsel),
        .rd_wr_n    (bus_rd_wr_n),
        .din        (bus_din),
        .status_now (flags),
        .rx_now     (rx_code),
        .dout       (bus_dout),
        .dout_en    (bus_dout_en),
        .wr_tx      (wr_tx),
        .wr_ctl     (wr_ctl),
        .rd_sts     (rd_sts),
        .wdata      (wdata),
        .snap_sts   (snap_sts)
    );

    xp_ctrl_regs #(.DW(DW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_tx   (wr_tx),
        .wr_ctl  (wr_ctl),
        .wdata   (wdata),
        .ctrl_a  (ctrl_a),
        .ctrl_b  (ctrl_b),
        .tx_code (tx_code),
        .tx_load (tx_load)
    );

    assign tone_out_en = ctrl_a[CA_TONE];
    assign cp_mode     = ctrl_a[CA_CPM];
    assign irq_en      = ctrl_a[CA_IRQ];
    assign burst_on    = ~ctrl_b[CB_BURSTN];
    assign test_on     = ctrl_b[CB_TEST];
    assign single_tone = ctrl_b[CB_SINGLE];
    assign column_sel  = ctrl_b[CB_COL];

    xp_status_flags #(.DW(DW)) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_full_evt  (rx_full_evt),
        .tx_empty_evt (tx_empty_evt),
        .dly_steer    (dly_steer),
        .cp_mode      (cp_mode),
        .burst_on     (burst_on),
        .rd_sts       (rd_sts),
        .snap_sts     (snap_sts),
        .flags        (flags)
    );

    xp_irq_mux u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cp_mode   (cp_mode),
        .irq_en    (irq_en),
        .test_on   (test_on),
        .rx_full   (flags[ST_RXF]),
        .tx_empty  (flags[ST_TXE]),
        .cp_sq     (cp_sq),
        .dly_steer (dly_steer),
        .irq_n     (irq_n)
    );

endmodule

// File: rtl/xp_port_chk.sv
module xp_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_cs_n,
    input logic       bus_phase,
    input logic       bus_rd_wr_n,
    input logic       bus_dout_en,
    input logic       rx_full_evt,
    input logic       dly_steer,
    input logic       cp_sq,
    input logic       tx_load,
    input logic       cp_mode,
    input logic       irq_en,
    input logic       burst_on,
    input logic       test_on,
    input logic [3:0] flags,
    input logic       irq_n
);

    // R2
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_en |-> (!bus_cs_n && bus_phase && bus_rd_wr_n));

    // R14
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load);

    // R12
    cp_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cp_mode && irq_en) |-> (irq_n == $past(cp_sq)));

    // R12
    cp_rx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cp_mode && rx_full_evt && !flags[2]) |-> !flags[2]);

    // R13
    steer_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cp_mode && test_on) |-> (irq_n == !$past(dly_steer)));

    // R8
    txe_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!burst_on) |-> !flags[1]);

    // R11
    event_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cp_mode && !test_on && irq_en && (flags[1] || flags[2])) |-> !irq_n);

endmodule

bind tone_xcvr_port xp_port_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_cs_n     (bus_cs_n),
    .bus_phase    (bus_phase),
    .bus_rd_wr_n  (bus_rd_wr_n),
    .bus_dout_en  (bus_dout_en),
    .rx_full_evt  (rx_full_evt),
    .dly_steer    (dly_steer),
    .cp_sq        (cp_sq),
    .tx_load      (tx_load),
    .cp_mode      (cp_mode),
    .irq_en       (irq_en),
    .burst_on     (burst_on),
    .test_on      (test_on),
    .flags        (flags),
    .irq_n        (irq_n)
);

// File: tb/tone_xcvr_port_tb.sv
module tone_xcvr_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs_n = 1'b1, bus_phase = 1'b0, bus_rsel = 1'b0, bus_rd_wr_n = 1'b1;
    logic [3:0] bus_din = '0, rx_code = '0;
    logic       rx_full_evt = 1'b0, tx_empty_evt = 1'b0, dly_steer = 1'b0, cp_sq = 1'b0;
    logic [3:0] bus_dout, tx_code;
    logic       bus_dout_en, tx_load, tone_out_en, cp_mode, irq_en, burst_on;
    logic       test_on, single_tone, column_sel, irq_n;

    typedef struct {
        string      tag;
        logic [3:0] exp;
    } item_t;

    item_t sbq[$];
    item_t it;
    bit    probe = 1'b0;
    int    n_cmp = 0, n_bad = 0, n_load = 0;

    always #10 clk = ~clk;

    tone_xcvr_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_phase(bus_phase),
        .bus_rsel(bus_rsel), .bus_rd_wr_n(bus_rd_wr_n), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .rx_code(rx_code),
        .rx_full_evt(rx_full_evt), .tx_empty_evt(tx_empty_evt), .dly_steer(dly_steer),
        .cp_sq(cp_sq), .tx_code(tx_code), .tx_load(tx_load), .tone_out_en(tone_out_en),
        .cp_mode(cp_mode), .irq_en(irq_en), .burst_on(burst_on), .test_on(test_on),
        .single_tone(single_tone), .column_sel(column_sel), .irq_n(irq_n)
    );

    always @(negedge clk) if (tx_load) n_load++;

    // monitor: compares read data against queued expectations, mid-cycle
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (probe) begin
                n_cmp++;
                if (sbq.size() == 0) begin
                    n_bad++;
                    $display("FAIL scoreboard empty: dout=%h expected nothing", bus_dout);
                end else begin
                    it = sbq.pop_front();
                    if (!bus_dout_en || bus_dout !== it.exp) begin
                        n_bad++;
                        $display("FAIL %s: dout=%h en=%b expected %h en=1",
                                 it.tag, bus_dout, bus_dout_en, it.exp);
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic rs, input logic [3:0] exp, input string tag,
                            input bit inject);
        @(negedge clk);
        bus_cs_n = 1'b0; bus_phase = 1'b1; bus_rsel = rs; bus_rd_wr_n = 1'b1;
        sbq.push_back('{tag, exp});
        @(negedge clk);
        probe = 1'b1;
        if (inject) rx_full_evt = 1'b1;
        @(negedge clk);
        probe = 1'b0;
        rx_full_evt = 1'b0;
        @(negedge clk);
        bus_cs_n = 1'b1; bus_phase = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_write(input logic rs, input logic [3:0] data);
        @(negedge clk);
        bus_cs_n = 1'b0; bus_phase = 1'b1; bus_rsel = rs; bus_rd_wr_n = 1'b0; bus_din = data;
        repeat (2) @(negedge clk);
        bus_cs_n = 1'b1; bus_phase = 1'b0; bus_rd_wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_rx();
        @(negedge clk); rx_full_evt = 1'b1;
        @(negedge clk); rx_full_evt = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_tx();
        @(negedge clk); tx_empty_evt = 1'b1;
        @(negedge clk); tx_empty_evt = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int loads_before;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 reset state
        chk("R6 irq_n", {3'b0, irq_n}, 4'h1);
        chk("R6 dout_en", {3'b0, bus_dout_en}, 4'h0);
        chk("R6 ctrl A outputs", {1'b0, irq_en, cp_mode, tone_out_en}, 4'h0);
        chk("R6 ctrl B outputs", {test_on, single_tone, column_sel, burst_on}, 4'h1);
        bus_read(1'b1, 4'b1000, "R6 R9 status after reset", 1'b0);

        // R3 / R4 / R5 control fields and redirect
        bus_write(1'b1, 4'b1001);
        chk("R3 ctrl A fields", {1'b0, irq_en, cp_mode, tone_out_en}, 4'b0001);
        bus_write(1'b1, 4'b1101);
        chk("R4 ctrl B fields", {test_on, single_tone, column_sel, burst_on}, 4'b0110);
        bus_write(1'b1, 4'b0100);
        chk("R5 write back in A", {1'b0, irq_en, cp_mode, tone_out_en}, 4'b0100);
        chk("R5 B untouched", {test_on, single_tone, column_sel, burst_on}, 4'b0110);
        bus_write(1'b1, 4'b1100);
        bus_write(1'b1, 4'b0000);
        chk("R4 burst back on", {test_on, single_tone, column_sel, burst_on}, 4'b0001);

        // R1 / R7 / R11 receive path
        rx_code = 4'h7;
        pulse_rx();
        chk("R11 irq low on rx", {3'b0, irq_n}, 4'h0);
        bus_read(1'b0, 4'h7, "R1 rx code read", 1'b0);
        bus_read(1'b1, 4'hD, "R7 status rx full", 1'b0);
        chk("R11 irq released after read", {3'b0, irq_n}, 4'h1);
        bus_read(1'b1, 4'h8, "R7 flags cleared", 1'b0);

        // R8 transmit empty
        pulse_tx();
        chk("R11 irq low on tx ready", {3'b0, irq_n}, 4'h0);
        bus_read(1'b1, 4'hB, "R8 tx empty set", 1'b0);
        pulse_tx();
        bus_write(1'b1, 4'b1100);
        bus_write(1'b1, 4'b0001);
        chk("R8 burst off", {3'b0, burst_on}, 4'h0);
        bus_read(1'b1, 4'b1001, "R8 cleared by burst off", 1'b0);
        pulse_tx();
        bus_read(1'b1, 4'b1000, "R8 ignored with burst off", 1'b0);

        // R9 steering bit
        dly_steer = 1'b1;
        bus_read(1'b1, 4'b0000, "R9 steering high", 1'b0);
        dly_steer = 1'b0;

        // R10 event during status read
        bus_read(1'b1, 4'b1000, "R10 snapshot excludes late event", 1'b1);
        bus_read(1'b1, 4'hD, "R10 late event kept", 1'b0);

        // R13 test mode
        bus_write(1'b1, 4'b1000);
        bus_write(1'b1, 4'b0010);
        dly_steer = 1'b1;
        repeat (3) @(negedge clk);
        chk("R13 steer high", {3'b0, irq_n}, 4'h0);
        dly_steer = 1'b0;
        repeat (3) @(negedge clk);
        chk("R13 steer low", {3'b0, irq_n}, 4'h1);

        // R12 call-progress mode
        bus_write(1'b1, 4'b0110);
        cp_sq = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 cp high", {3'b0, irq_n}, 4'h1);
        cp_sq = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 cp low", {3'b0, irq_n}, 4'h0);
        pulse_rx();
        bus_read(1'b1, 4'b1000, "R12 rx ignored in cp", 1'b0);
        bus_write(1'b1, 4'b0010);
        chk("R12 cp without irq_en", {3'b0, irq_n}, 4'h1);

        // R14 transmit write
        loads_before = n_load;
        bus_write(1'b0, 4'h5);
        chk("R14 tx code", tx_code, 4'h5);
        chk("R14 one load pulse", 4'(n_load - loads_before), 4'h1);

        // R2 no access while phase low
        @(negedge clk);
        bus_cs_n = 1'b0; bus_phase = 1'b0; bus_rsel = 1'b1; bus_rd_wr_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 no drive phase low", {3'b0, bus_dout_en}, 4'h0);
        bus_cs_n = 1'b1; bus_phase = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 no drive deselected", {3'b0, bus_dout_en}, 4'h0);
        bus_phase = 1'b0;
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule